// File: doc/BRIEF.md
# Serial-Out Condition Code Register

This block keeps the status flags from the most recent flag-producing ALU step and hands them to the control sequencer one bit at a time. It holds four flags in a small shift register. A registered output, `cc_bit`, always shows the flag at the output end. The sequencer uses that bit as one address line of its control store. To branch on a flag that is not at the output end, the microcode first spends shift cycles moving that flag into place.

Two control inputs drive the block each cycle. The enable `cc_en` decides whether the register changes at all. The select `cc_load_nshift` then chooses what happens. When it is 1, all four flags are captured in parallel from `alu_flags`. When it is 0, the contents move one place toward the output and a 0 enters at the far end.

Three operations are decoded from these two inputs:
- HOLD: `cc_en` is 0.
- LOAD: `cc_en` is 1 and `cc_load_nshift` is 1.
- SHIFT: `cc_en` is 1 and `cc_load_nshift` is 0.

The register can move between any of these operations on any cycle. Nothing in the block orders them.

Top module: `cc_serial_flags`

## Requirements
- R1: A synchronous reset, with `rst_n` low at a rising clock edge, clears every stored flag to 0. This applies even if a LOAD is requested in the same cycle, so `cc_bit` reads 0 after the edge.
- R2: In LOAD, all of `alu_flags` is captured at the clock edge. The bit positions in `alu_flags` are:
  - bit 0: carry
  - bit 1: zero
  - bit 2: negative
  - bit 3: overflow

  After the edge, `cc_bit` shows the captured carry.
- R3: Each SHIFT moves the contents one position toward the output. After k SHIFTs that follow a LOAD (k = 1, 2, 3), `cc_bit` equals `alu_flags` bit k as it was captured.
- R4: A SHIFT fills the vacated far end with 0. After as many SHIFTs as there are flags, `cc_bit` reads 0, and it stays 0 under further SHIFTs.
- R5: In HOLD, the stored flags and `cc_bit` stay unchanged, whatever the values of `cc_load_nshift` and `alu_flags`. Later SHIFTs reveal the same flags as before the HOLD.
- R6: A LOAD replaces the whole contents, including when flags from an earlier LOAD are partly shifted out. No earlier bits survive the LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_flags | input | 4 | ALU flag vector: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow |
| cc_en | input | 1 | Enable; when 0 the register holds |
| cc_load_nshift | input | 1 | 1 selects a parallel load, 0 selects a one-place shift |
| cc_bit | output | 1 | Flag currently at the output position |

## Verification
Two functions can meet in one cycle. The first is a fresh parallel load arriving while an earlier flag set is only partly shifted out. The second is a HOLD cycle that sees a load select and changed ALU flags, which a faulty enable path would capture.

The bench provokes both cases:
- It issues a LOAD directly after one SHIFT.
- It inserts HOLD cycles with the select high and `alu_flags` driven to a different pattern.

It judges both cases at `cc_bit`. It checks the value shown right after each such cycle. It then shifts the rest out and compares every revealed bit against the flag set that should be stored.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int unsigned CC_NFLAGS = 4;

    // Flag positions inside the parallel flag vector
    localparam int unsigned CC_IDX_CARRY = 0;
    localparam int unsigned CC_IDX_ZERO  = 1;
    localparam int unsigned CC_IDX_NEG   = 2;
    localparam int unsigned CC_IDX_OVF   = 3;

    typedef enum logic [1:0] {
        CC_HOLD  = 2'd0,
        CC_LOAD  = 2'd1,
        CC_SHIFT = 2'd2
    } cc_op_e;

endpackage

// File: rtl/cc_op_decode.sv
module cc_op_decode
    import cc_pkg::*;
(
    input  logic   en_i,
    input  logic   load_nshift_i,
    output cc_op_e op_o
);

    always_comb begin
        unique case ({en_i, load_nshift_i})
            2'b11:   op_o = CC_LOAD;
            2'b10:   op_o = CC_SHIFT;
            2'b01:   op_o = CC_HOLD;
            default: op_o = CC_HOLD;
        endcase
    end

endmodule

// File: rtl/cc_shift_store.sv
module cc_shift_store
    import cc_pkg::*;
#(
    parameter int unsigned NFLAGS = CC_NFLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cc_op_e            op_i,
    input  logic [NFLAGS-1:0] par_i,
    output logic [NFLAGS-1:0] q_o
);

    localparam int unsigned TOP = NFLAGS - 1;

    logic [NFLAGS-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            unique case (op_i)
                CC_LOAD:  q_r <= par_i;
                CC_SHIFT: q_r <= {1'b0, q_r[TOP:1]};
                default:  q_r <= q_r;
            endcase
        end
    end

    assign q_o = q_r;

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CC_LOAD) |=> (q_r == $past(par_i)));                  // R2

    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CC_SHIFT) |=> (q_r[0] == $past(q_r[1])));             // R3

    AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CC_SHIFT) |=> (q_r[TOP] == 1'b0));                    // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CC_HOLD) |=> $stable(q_r));                           // R5

endmodule

// File: rtl/cc_serial_flags.sv
module cc_serial_flags
    import cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CC_NFLAGS-1:0] alu_flags,
    input  logic                 cc_en,
    input  logic                 cc_load_nshift,
    output logic                 cc_bit
);

    cc_op_e                 op;
    logic [CC_NFLAGS-1:0]   store_q;

    cc_op_decode u_decode (
        .en_i          (cc_en),
        .load_nshift_i (cc_load_nshift),
        .op_o          (op)
    );

    cc_shift_store #(
        .NFLAGS (CC_NFLAGS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .par_i (alu_flags),
        .q_o   (store_q)
    );

    assign cc_bit = store_q[CC_IDX_CARRY];

    AST_OUT_TRACKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && cc_load_nshift) |=> (cc_bit == $past(alu_flags[CC_IDX_CARRY]))); // R6

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_en) |=> (cc_bit == $past(cc_bit)));                                    // R5

endmodule

// File: tb/cc_serial_flags_tb_top.sv
module cc_serial_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] alu_flags;
    logic       cc_en;
    logic       cc_load_nshift;
    logic       cc_bit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    cc_serial_flags dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .alu_flags      (alu_flags),
        .cc_en          (cc_en),
        .cc_load_nshift (cc_load_nshift),
        .cc_bit         (cc_bit)
    );

    task automatic check_now(input logic exp, input string req);
        n_checks++;
        if (cc_bit !== exp) begin
            n_fails++;
            $display("FAIL %s: cc_bit actual %b expected %b", req, cc_bit, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the bit expected after the edge
    task automatic drive(input logic en, input logic ld, input logic [3:0] fl,
                         input logic exp, input string req);
        item_t it;
        @(negedge clk);
        cc_en          = en;
        cc_load_nshift = ld;
        alu_flags      = fl;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check_now(it.exp, it.req);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n          = 1'b0;
        cc_en          = 1'b1;
        cc_load_nshift = 1'b1;
        alu_flags      = 4'b1111;
        repeat (3) @(negedge clk);
        check_now(1'b0, "R1");                 // reset wins over requested load
        cc_en = 1'b1; cc_load_nshift = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_now(1'b0, "R1");

        // R2/R3/R4: load 1010 (c=0,z=1,n=0,v=1), shift through and past
        drive(1, 1, 4'b1010, 1'b0, "R2 carry");
        drive(1, 0, 4'b0000, 1'b1, "R3 zero");
        drive(1, 0, 4'b1111, 1'b0, "R3 negative");
        drive(1, 0, 4'b0000, 1'b1, "R3 overflow");
        drive(1, 0, 4'b1111, 1'b0, "R4 fill");
        drive(1, 0, 4'b1111, 1'b0, "R4 fill stays");

        // R5: hold with load select high and different flags
        drive(1, 1, 4'b0101, 1'b1, "R2 carry");
        drive(0, 1, 4'b0000, 1'b1, "R5 hold ld");
        drive(0, 0, 4'b1010, 1'b1, "R5 hold sh");
        drive(1, 0, 4'b0000, 1'b0, "R5 zero kept");
        drive(1, 0, 4'b0000, 1'b1, "R5 negative kept");

        // R6: new load mid-shift, old bits must be gone
        drive(1, 1, 4'b1111, 1'b1, "R2 carry");
        drive(1, 0, 4'b0000, 1'b1, "R3 zero");
        drive(1, 1, 4'b0010, 1'b0, "R6 reload carry");
        drive(1, 0, 4'b0000, 1'b1, "R6 reload zero");
        drive(1, 0, 4'b1111, 1'b0, "R6 reload negative");
        drive(1, 0, 4'b1111, 1'b0, "R6 reload overflow");
        drive(1, 0, 4'b1111, 1'b0, "R4 fill");

        // R3 overflow alone, with holds in between
        drive(1, 1, 4'b1000, 1'b0, "R2 carry");
        drive(0, 1, 4'b0111, 1'b0, "R5 hold");
        drive(1, 0, 4'b0000, 1'b0, "R3 zero");
        drive(1, 0, 4'b0000, 1'b0, "R3 negative");
        drive(1, 0, 4'b0000, 1'b1, "R3 overflow");
        drive(1, 0, 4'b0000, 1'b0, "R4 fill");

        // reset mid-content clears everything
        drive(1, 1, 4'b1111, 1'b1, "R2 carry");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        cc_en = 1'b0;
        @(negedge clk);
        check_now(1'b0, "R1");
        rst_n = 1'b1;
        drive(1, 0, 4'b0000, 1'b0, "R1 cleared");
        drive(1, 0, 4'b0000, 1'b0, "R1 cleared");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule